// File: doc/BRIEF.md
# Fractional Sample Strobe Generator

This block divides a fast reference clock by a rational ratio to produce a one-cycle sample strobe. The strobe paces the consumer of an audio sample FIFO. Software programs one 32-bit configuration word that holds a 24-bit numerator N and an 8-bit field M. Over time the interval between strobes converges to N/(M+1) reference cycles.

The block uses an error accumulator rather than an integer divider. On each enabled reference cycle it adds M+1. When the running sum reaches N, it takes N back off and emits a strobe. The block has an enable input that pauses the stream while keeping its phase. A restart input clears the phase without touching the ratio. Writing the configuration word also clears the phase, so a new ratio takes effect at once.

Top module: `frac_strobe_gen`

## Requirements
- R1: The configuration word splits into N = cfg_data[31:8] (24 bits, unsigned) and M = cfg_data[7:0]. The step added per enabled cycle is M+1, so denominators from 1 to 256 can be reached.
- R2: When N > M+1 and the accumulator starts clear, exactly K·(M+1) strobes appear over K·N enabled cycles, for any whole K.
- R3: The strobe for an enabled cycle appears in the following cycle. After a clear, the first strobe follows enabled cycle number ceil(N/(M+1)).
- R4: When N is nonzero and N ≤ M+1, a strobe follows every enabled cycle.
- R5: When N is 0, no strobe is ever produced.
- R6: While en is low, the strobe is low in the following cycle and the accumulator holds its value. Pausing therefore does not change the total count over a given number of enabled cycles.
- R7: A cycle with cfg_wr high loads N and M, clears the accumulator and forces the strobe low in the next cycle. The new ratio applies from the next enabled cycle.
- R8: A cycle with restart high clears the accumulator and forces the strobe low in the next cycle. The stored ratio is kept.
- R9: After reset the strobe is low and N and M are 0, so no strobe occurs until a configuration is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the accumulator this cycle |
| restart | input | 1 | Clear the accumulator, keep the ratio |
| cfg_wr | input | 1 | Load cfg_data into the ratio fields |
| cfg_data | input | 32 | Ratio word: N in bits 31:8, M in bits 7:0 |
| strobe | output | 1 | One-cycle sample strobe |

## Verification
The assertions assume that reset is applied before any write. They also assume that a configuration write and a restart arriving together act as one clear, and that en may change on any cycle. The bench drives only one control event at a time, on the falling edge. It counts strobes over windows that are exact multiples of N, so the expected totals are integers that follow from R2. The ratios used cover the full 256 denominator, a denominator of 1, N equal to the step, N equal to 0, and a pause in the middle of a window.

// File: rtl/frac_strobe_gen.sv
module frac_strobe_gen #(
  parameter int N_W = 24,
  parameter int M_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               restart,
  input  logic               cfg_wr,
  input  logic [N_W+M_W-1:0] cfg_data,
  output logic               strobe
);
  localparam int ACC_W = N_W + 1;

  logic [N_W-1:0]   n_q;
  logic [M_W-1:0]   m_q;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] n_ext;
  logic             n_zero, every, hit;

  assign step   = ACC_W'(m_q) + ACC_W'(1);
  assign n_ext  = ACC_W'(n_q);
  assign sum    = acc_q + step;
  assign n_zero = (n_q == '0);
  assign every  = !n_zero && (n_ext <= step);
  assign hit    = !n_zero && (every || sum >= n_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_q    <= '0;
      m_q    <= '0;
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (cfg_wr) begin
      n_q    <= cfg_data[N_W+M_W-1:M_W];
      m_q    <= cfg_data[M_W-1:0];
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (restart) begin
      acc_q  <= '0;
      strobe <= 1'b0;
    end else if (en) begin
      strobe <= hit;
      if (!n_zero && !every)
        acc_q <= hit ? sum - n_ext : sum;
    end else begin
      strobe <= 1'b0;
    end
  end

  AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
    (n_ext > step) |-> (acc_q < n_ext)); // R2
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cfg_wr && !restart && every) |=> strobe); // R4
  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (n_zero && !cfg_wr) |=> !strobe); // R5
  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cfg_wr && !restart) |=> (!strobe && $stable(acc_q))); // R6
  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!strobe && acc_q == '0)); // R7
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cfg_wr) |=> (!strobe && acc_q == '0 && $stable(n_q))); // R8
endmodule

// File: tb/frac_strobe_gen_test.sv
module frac_strobe_gen_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        restart = 0;
  logic        cfg_wr = 0;
  logic [31:0] cfg_data = '0;
  logic        strobe;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  frac_strobe_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en), .restart(restart),
    .cfg_wr(cfg_wr), .cfg_data(cfg_data), .strobe(strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int n, input int m);
    @(negedge clk);
    cfg_data = {n[23:0], m[7:0]};
    cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic run(input int cycles, output int cnt, output int first);
    cnt = 0;
    first = 0;
    en = 1;
    for (int i = 1; i <= cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (strobe) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    en = 0;
    @(negedge clk);
    cnt += strobe;
  endtask

  task automatic t_reset;
    int c, f;
    check("R9 strobe after reset", strobe, 0);
    run(10, c, f);
    check("R9 no strobe before config", c, 0);
  endtask

  task automatic t_ratio(input int n, input int m, input int k);
    int c, f;
    write_cfg(n, m);
    run(k * n, c, f);
    check("R2 exact count over K*N", c, k * (m + 1));
    check("R3 first strobe position", f, (n + m) / (m + 1));
  endtask

  task automatic t_full_rate;
    int c, f;
    write_cfg(5, 4);
    run(20, c, f);
    check("R4 N equal to step", c, 20);
    write_cfg(3, 255);
    run(12, c, f);
    check("R4 R1 denominator 256 above N", c, 12);
  endtask

  task automatic t_zero;
    int c, f;
    write_cfg(0, 7);
    run(50, c, f);
    check("R5 N zero silent", c, 0);
  endtask

  task automatic t_pause;
    int c1, c2, cp, f;
    write_cfg(10, 2);
    run(7, c1, f);
    cp = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      cp += strobe;
    end
    check("R6 no strobe while paused", cp, 0);
    run(23, c2, f);
    check("R6 phase kept across pause", c1 + c2, 9);
  endtask

  task automatic t_restart;
    int c, f;
    write_cfg(10, 2);
    run(5, c, f);
    check("R8 strobes before restart", c, 1);
    @(negedge clk);
    restart = 1;
    @(negedge clk);
    restart = 0;
    check("R8 strobe low after restart", strobe, 0);
    run(3, c, f);
    check("R8 accumulator cleared", c, 0);
    run(1, c, f);
    check("R8 ratio kept", c, 1);
  endtask

  task automatic t_rewrite;
    int c, f;
    write_cfg(10, 2);
    run(8, c, f);
    write_cfg(10, 2);
    run(3, c, f);
    check("R7 write clears accumulator", c, 0);
    write_cfg(44, 9);
    run(44, c, f);
    check("R7 new ratio count", c, 10);
    check("R7 new ratio first strobe", f, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ratio(7, 2, 4);
    t_ratio(1000, 255, 3);
    t_ratio(4096, 0, 1);
    t_ratio(13, 4, 2);
    t_full_rate();
    t_zero();
    t_pause();
    t_restart();
    t_rewrite();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule